// File: doc/BRIEF.md
# Receiver Idle-Line and Wakeup Detector

This block sits beside a serial receiver's deserializer and watches the sampled receive level together with the receiver's bit-timing strobes. It counts consecutive high bit times and reports an idle line once the count reaches the character length. That length is ten bit times for 8-bit characters and eleven for 9-bit characters. A mode input selects where counting may begin. In one mode the high data bits and the stop bit at the end of a character count toward idle. In the other mode they are excluded and counting begins only after the stop bit.

The block also keeps a receiver-sleep state. A sleep request puts the receiver to sleep, and while it sleeps the characters it receives are held back from the consumer. One of two methods wakes it. With idle-line wakeup, a detected idle line wakes it. With address-mark wakeup, a character whose most significant data bit is set wakes it, and that character is delivered. The idle flag is raised once per idle stretch and is cleared when the next character starts.

Top module: `rxiw_detector`

## Requirements
- R1: After reset, idle_o is 0, awake_o is 1 and rx_valid_o is 0.
- R2: With nine_bit_i=0, idle_o becomes 1 in the cycle after the 10th consecutive counted high bit tick (rx_level_i=1 with bit_tick_i=1). After 9 such ticks it is still 0.
- R3: With nine_bit_i=1, the threshold is 11 counted high bit ticks. After 10 such ticks idle_o is still 0.
- R4: A bit tick with rx_level_i=0 restarts the high-bit count from zero, even with no start strobe.
- R5: With idle_after_stop_i=0, high data-bit ticks and the stop-bit tick of a character count toward idle.
- R6: With idle_after_stop_i=1, no bit tick from the start strobe up to and including the tick that carries stop_done_i counts toward idle.
- R7: idle_o is raised at most once per idle stretch and stays 1 through further high ticks. A start_det_i strobe clears it in the next cycle and re-arms detection.
- R8: A sleep_req_i pulse while awake makes awake_o 0 in the next cycle. A sleep_req_i pulse while asleep has no effect. While asleep, characters are not delivered unless they wake the receiver.
- R9: With wake_mark_i=0 (idle-line wakeup), an idle detection while asleep sets awake_o to 1 and leaves idle_o unchanged.
- R10: With wake_mark_i=1 (address-mark wakeup), a character whose mark bit is set wakes the receiver and is delivered. The mark bit is char_i[7] when nine_bit_i=0 and char_i[8] when nine_bit_i=1. Other characters leave it asleep and are suppressed. The idle flag keeps working normally in this mode while asleep.
- R11: When a character completes (stop_done_i) and is delivered, rx_valid_o is 1 for exactly the next cycle, with rx_data_o equal to char_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_level_i | input | 1 | Sampled receive line level, valid with bit_tick_i |
| bit_tick_i | input | 1 | One-cycle strobe at each bit-time sample |
| start_det_i | input | 1 | Start bit detected (coincides with its low tick) |
| stop_done_i | input | 1 | Stop bit sampled, character complete |
| char_i | input | DATA_W | Received character, valid with stop_done_i |
| nine_bit_i | input | 1 | 1 selects 9-bit characters |
| idle_after_stop_i | input | 1 | 1 starts idle counting only after the stop bit |
| wake_mark_i | input | 1 | 0 idle-line wakeup, 1 address-mark wakeup |
| sleep_req_i | input | 1 | Request to put the receiver to sleep |
| idle_o | output | 1 | Idle-line flag |
| awake_o | output | 1 | 1 awake, 0 asleep |
| rx_valid_o | output | 1 | Delivered-character strobe |
| rx_data_o | output | DATA_W | Delivered character |

## Verification
Every cycle, the assertions check that a low tick clears the count and that ticks inside a frame stay out of the count in after-stop mode. They also check that a detection is never repeated on the next tick, that a start strobe clears the flag, and that each sleep and wake transition follows its trigger. Only the bench's scenarios can show the exact thresholds of ten and eleven ticks, the difference between the two counting origins across a whole character, and which characters are suppressed or delivered. The bench's reference model is compared with every output on every clock.

// File: rtl/rxiw_pkg.sv
package rxiw_pkg;
   typedef enum logic {
      WAKE_ON_IDLE = 1'b0,
      WAKE_ON_MARK = 1'b1
   } wake_sel_e;

   typedef enum logic {
      CNT_FROM_START = 1'b0,
      CNT_FROM_STOP  = 1'b1
   } idle_origin_e;
endpackage

// File: rtl/rxiw_idle_counter.sv
module rxiw_idle_counter
   import rxiw_pkg::*;
#(
   parameter int SHORT_BITS = 10,
   parameter int LONG_BITS  = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rx_level_i,
   input  logic         bit_tick_i,
   input  logic         start_det_i,
   input  logic         stop_done_i,
   input  logic         nine_bit_i,
   input  idle_origin_e origin_i,
   output logic         idle_evt_o
);
   localparam int CNT_W = $clog2(LONG_BITS + 1);
   localparam logic [CNT_W-1:0] THR_S = CNT_W'(SHORT_BITS);
   localparam logic [CNT_W-1:0] THR_L = CNT_W'(LONG_BITS);
   localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] thr;
   logic             in_frame_q;
   logic             armed_q;
   logic             count_en;

   assign thr      = nine_bit_i ? THR_L : THR_S;
   assign count_en = (origin_i == CNT_FROM_START) || !in_frame_q;
   assign idle_evt_o = bit_tick_i && rx_level_i && count_en && armed_q &&
                       !start_det_i && (cnt_q >= (thr - ONE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start_det_i) begin
         cnt_q <= '0;
      end else if (bit_tick_i) begin
         if (!rx_level_i || !count_en) begin
            cnt_q <= '0;
         end else if (cnt_q < THR_L) begin
            cnt_q <= cnt_q + ONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame_q <= 1'b0;
      end else if (start_det_i) begin
         in_frame_q <= 1'b1;
      end else if (stop_done_i) begin
         in_frame_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b1;
      end else if (start_det_i) begin
         armed_q <= 1'b1;
      end else if (idle_evt_o) begin
         armed_q <= 1'b0;
      end
   end

   p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= THR_L);

   p_low_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_tick_i && !rx_level_i) |=> (cnt_q == '0));

   p_frame_excluded_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (origin_i == CNT_FROM_STOP && in_frame_q && bit_tick_i) |=> (cnt_q == '0));

   p_once_per_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      idle_evt_o |=> !idle_evt_o);
endmodule

// File: rtl/rxiw_mark_pick.sv
module rxiw_mark_pick #(
   parameter int DATA_W = 9
) (
   input  logic [DATA_W-1:0] char_i,
   input  logic              nine_bit_i,
   output logic              mark_o
);
   generate
      if (DATA_W > 8) begin : g_nine
         assign mark_o = nine_bit_i ? char_i[8] : char_i[7];
      end else begin : g_eight
         logic unused_nine;
         assign unused_nine = nine_bit_i;
         assign mark_o      = char_i[DATA_W-1];
      end
   endgenerate
endmodule

// File: rtl/rxiw_wake_ctrl.sv
module rxiw_wake_ctrl
   import rxiw_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      sleep_req_i,
   input  logic      idle_evt_i,
   input  logic      frame_end_i,
   input  logic      mark_i,
   input  wake_sel_e wake_sel_i,
   output logic      asleep_o
);
   logic wake_now;

   assign wake_now = (wake_sel_i == WAKE_ON_IDLE) ? idle_evt_i
                                                  : (frame_end_i && mark_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         asleep_o <= 1'b0;
      end else if (asleep_o) begin
         if (wake_now) asleep_o <= 1'b0;
      end else if (sleep_req_i) begin
         asleep_o <= 1'b1;
      end
   end

   p_sleep_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!asleep_o && sleep_req_i) |=> asleep_o);

   p_idle_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep_o && wake_sel_i == WAKE_ON_IDLE && idle_evt_i) |=> !asleep_o);

   p_mark_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep_o && wake_sel_i == WAKE_ON_MARK && frame_end_i && mark_i) |=> !asleep_o);

   p_mark_stay_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep_o && wake_sel_i == WAKE_ON_MARK && !(frame_end_i && mark_i)) |=> asleep_o);
endmodule

// File: rtl/rxiw_deliver.sv
module rxiw_deliver #(
   parameter int DATA_W  = 9,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go_i,
   input  logic [DATA_W-1:0] char_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] data_o
);
   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               valid_o <= 1'b0;
               data_o  <= '0;
            end else begin
               valid_o <= go_i;
               if (go_i) data_o <= char_i;
            end
         end
         p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_o && !$past(go_i, 1)) |-> 1'b0);
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign valid_o    = go_i;
         assign data_o     = go_i ? char_i : '0;
      end
   endgenerate
endmodule

// File: rtl/rxiw_detector.sv
module rxiw_detector
   import rxiw_pkg::*;
#(
   parameter int DATA_W     = 9,
   parameter int SHORT_BITS = 10,
   parameter int LONG_BITS  = 11,
   parameter bit OUT_REG    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_level_i,
   input  logic              bit_tick_i,
   input  logic              start_det_i,
   input  logic              stop_done_i,
   input  logic [DATA_W-1:0] char_i,
   input  logic              nine_bit_i,
   input  logic              idle_after_stop_i,
   input  logic              wake_mark_i,
   input  logic              sleep_req_i,
   output logic              idle_o,
   output logic              awake_o,
   output logic              rx_valid_o,
   output logic [DATA_W-1:0] rx_data_o
);
   generate
      if (DATA_W != 8 && DATA_W != 9) begin : g_bad_width
         $error("rxiw_detector: DATA_W must be 8 or 9");
      end
      if (SHORT_BITS < 2 || LONG_BITS < SHORT_BITS) begin : g_bad_thr
         $error("rxiw_detector: need 2 <= SHORT_BITS <= LONG_BITS");
      end
   endgenerate

   wake_sel_e    wake_sel;
   idle_origin_e origin;
   logic         idle_evt;
   logic         mark;
   logic         asleep;
   logic         deliver;
   logic         flag_set;

   assign wake_sel = wake_sel_e'(wake_mark_i);
   assign origin   = idle_origin_e'(idle_after_stop_i);

   rxiw_idle_counter #(
      .SHORT_BITS (SHORT_BITS),
      .LONG_BITS  (LONG_BITS)
   ) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_level_i  (rx_level_i),
      .bit_tick_i  (bit_tick_i),
      .start_det_i (start_det_i),
      .stop_done_i (stop_done_i),
      .nine_bit_i  (nine_bit_i),
      .origin_i    (origin),
      .idle_evt_o  (idle_evt)
   );

   rxiw_mark_pick #(.DATA_W(DATA_W)) u_mark (
      .char_i     (char_i),
      .nine_bit_i (nine_bit_i),
      .mark_o     (mark)
   );

   rxiw_wake_ctrl u_wake (
      .clk         (clk),
      .rst_n       (rst_n),
      .sleep_req_i (sleep_req_i),
      .idle_evt_i  (idle_evt),
      .frame_end_i (stop_done_i),
      .mark_i      (mark),
      .wake_sel_i  (wake_sel),
      .asleep_o    (asleep)
   );

   assign deliver  = stop_done_i && (!asleep || (wake_sel == WAKE_ON_MARK && mark));
   assign flag_set = idle_evt && !(asleep && wake_sel == WAKE_ON_IDLE);

   rxiw_deliver #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_dlv (
      .clk     (clk),
      .rst_n   (rst_n),
      .go_i    (deliver),
      .char_i  (char_i),
      .valid_o (rx_valid_o),
      .data_o  (rx_data_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_o <= 1'b0;
      end else if (flag_set) begin
         idle_o <= 1'b1;
      end else if (start_det_i) begin
         idle_o <= 1'b0;
      end
   end

   assign awake_o = !asleep;

   p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      start_det_i |=> !idle_o);

   p_flag_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!awake_o && !wake_mark_i && bit_tick_i && !start_det_i) |=> $stable(idle_o));

   generate
      if (OUT_REG) begin : g_dlv_chk
         p_awake_deliver_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (stop_done_i && awake_o) |=> (rx_valid_o && rx_data_o == $past(char_i)));
         p_asleep_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (stop_done_i && !awake_o && !wake_mark_i) |=> !rx_valid_o);
      end
   endgenerate
endmodule

// File: tb/rxiw_detector_bench.sv
`timescale 1ns/1ps
module rxiw_detector_bench;
   localparam int DW = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          rx_level = 1'b1;
   logic          bit_tick = 1'b0;
   logic          start_det = 1'b0;
   logic          stop_done = 1'b0;
   logic [DW-1:0] char_in = '0;
   logic          nine_bit = 1'b0;
   logic          after_stop = 1'b0;
   logic          wake_mark = 1'b0;
   logic          sleep_req = 1'b0;
   logic          idle_o, awake_o, rx_valid_o;
   logic [DW-1:0] rx_data_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   rxiw_detector u_rxiw_detector (
      .clk (clk), .rst_n (rst_n), .rx_level_i (rx_level), .bit_tick_i (bit_tick),
      .start_det_i (start_det), .stop_done_i (stop_done), .char_i (char_in),
      .nine_bit_i (nine_bit), .idle_after_stop_i (after_stop), .wake_mark_i (wake_mark),
      .sleep_req_i (sleep_req), .idle_o (idle_o), .awake_o (awake_o),
      .rx_valid_o (rx_valid_o), .rx_data_o (rx_data_o)
   );

   // Behavioural reference model, advanced on each rising edge.
   int m_run = 0;   // consecutive counted high ticks
   bit m_inside = 0, m_may_flag = 1, m_sleep = 0, m_idle = 0, m_valid = 0;
   int m_data = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_inside = 0; m_may_flag = 1; m_sleep = 0;
         m_idle = 0; m_valid = 0; m_data = 0;
      end else begin
         int need;
         bit counts, hit, mk, give, was_sleep;
         need = nine_bit ? 11 : 10;
         counts = !after_stop || !m_inside;
         hit = bit_tick && rx_level && counts && m_may_flag && !start_det && (m_run + 1 >= need);
         mk = nine_bit ? char_in[8] : char_in[7];
         was_sleep = m_sleep;
         give = stop_done && (!was_sleep || (wake_mark && mk));
         m_valid = give;
         if (give) m_data = int'(char_in);
         if (hit && !(was_sleep && !wake_mark)) m_idle = 1;
         else if (start_det) m_idle = 0;
         if (was_sleep) begin
            if ((!wake_mark && hit) || (wake_mark && stop_done && mk)) m_sleep = 0;
         end else if (sleep_req) m_sleep = 1;
         if (start_det) m_run = 0;
         else if (bit_tick) begin
            if (!rx_level || !counts) m_run = 0;
            else if (m_run < 11) m_run++;
         end
         if (start_det) m_may_flag = 1; else if (hit) m_may_flag = 0;
         if (start_det) m_inside = 1; else if (stop_done) m_inside = 0;
      end
   end

   task automatic check(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         check("R2 model idle_o", idle_o, m_idle);
         check("R8 model awake_o", awake_o, !m_sleep);
         check("R11 model rx_valid_o", rx_valid_o, m_valid);
         check("R11 model rx_data_o", int'(rx_data_o), m_data);
      end
   end

   task automatic tick(input bit lvl, input bit st, input bit sp, input logic [DW-1:0] ch);
      @(negedge clk);
      rx_level = lvl; bit_tick = 1'b1; start_det = st; stop_done = sp;
      if (sp) char_in = ch;
      @(negedge clk);
      bit_tick = 1'b0; start_det = 1'b0; stop_done = 1'b0; rx_level = 1'b1;
   endtask

   task automatic highs(input int n);
      for (int i = 0; i < n; i++) tick(1'b1, 1'b0, 1'b0, '0);
   endtask

   task automatic send(input logic [DW-1:0] d);
      tick(1'b0, 1'b1, 1'b0, '0);
      for (int i = 0; i < 8; i++) tick(d[i], 1'b0, 1'b0, '0);
      if (nine_bit) tick(d[8], 1'b0, 1'b0, '0);
      tick(1'b1, 1'b0, 1'b1, d);
   endtask

   task automatic sleep_pulse();
      @(negedge clk); sleep_req = 1'b1;
      @(negedge clk); sleep_req = 1'b0;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle_o after reset", idle_o, 0);
      check("R1 awake_o after reset", awake_o, 1);
      check("R1 rx_valid_o after reset", rx_valid_o, 0);

      // R2: ten high ticks in 8-bit mode
      highs(9);  check("R2 idle_o after 9 ticks", idle_o, 0);
      highs(1);  check("R2 idle_o after 10 ticks", idle_o, 1);
      highs(3);  check("R7 idle_o held over extra ticks", idle_o, 1);

      // R7 clear on start, R5 trailing highs count from the start bit
      tick(1'b0, 1'b1, 1'b0, '0);
      check("R7 idle_o cleared by start", idle_o, 0);
      for (int i = 0; i < 8; i++) tick(1'b1, 1'b0, 1'b0, '0);
      tick(1'b1, 1'b0, 1'b1, 9'h0FF);
      check("R5 idle_o after stop", idle_o, 0);
      check("R11 rx_valid_o after stop", rx_valid_o, 1);
      check("R11 rx_data_o after stop", int'(rx_data_o), 'h0FF);
      highs(1);
      check("R5 idle_o after one extra tick", idle_o, 1);
      check("R11 rx_valid_o single cycle", rx_valid_o, 0);

      // R6: count only after the stop bit
      after_stop = 1'b1;
      send(9'h0FF);
      highs(9);  check("R6 idle_o after 9 post-stop ticks", idle_o, 0);
      highs(1);  check("R6 idle_o after 10 post-stop ticks", idle_o, 1);

      // R4: a low tick restarts the count
      after_stop = 1'b0;
      send(9'h000);
      highs(5);
      tick(1'b0, 1'b0, 1'b0, '0);
      highs(9);  check("R4 idle_o 9 ticks after low", idle_o, 0);
      highs(1);  check("R4 idle_o 10 ticks after low", idle_o, 1);

      // R3: eleven ticks in 9-bit mode
      nine_bit = 1'b1; after_stop = 1'b1;
      send(9'h1FF);
      highs(10); check("R3 idle_o after 10 ticks", idle_o, 0);
      highs(1);  check("R3 idle_o after 11 ticks", idle_o, 1);

      // R8: sleep entry, second request ignored
      nine_bit = 1'b0; after_stop = 1'b0;
      sleep_pulse(); check("R8 awake_o after sleep request", awake_o, 0);
      sleep_pulse(); check("R8 awake_o after second request", awake_o, 0);

      // R9: idle-line wakeup
      send(9'h055);
      check("R8 character suppressed while asleep", rx_valid_o, 0);
      highs(8);  check("R9 still asleep before idle", awake_o, 0);
      highs(1);
      check("R9 awake_o after idle", awake_o, 1);
      check("R9 idle_o not set by waking idle", idle_o, 0);

      // R10: address-mark wakeup, 8-bit
      wake_mark = 1'b1;
      sleep_pulse();
      send(9'h012);
      check("R10 unmarked char suppressed", rx_valid_o, 0);
      check("R10 unmarked char keeps sleep", awake_o, 0);
      send(9'h085);
      check("R10 marked char delivered", rx_valid_o, 1);
      check("R10 marked char data", int'(rx_data_o), 'h085);
      check("R10 marked char wakes", awake_o, 1);

      // R10: 9-bit mark uses bit 8
      nine_bit = 1'b1;
      sleep_pulse();
      send(9'h080);
      check("R10 bit7 not a mark in 9-bit", awake_o, 0);
      check("R10 bit7 char suppressed", rx_valid_o, 0);
      highs(10);
      check("R10 idle_o works while asleep", idle_o, 1);
      check("R10 idle does not wake", awake_o, 0);
      send(9'h100);
      check("R10 bit8 mark delivered", rx_valid_o, 1);
      check("R10 bit8 mark data", int'(rx_data_o), 'h100);
      check("R10 bit8 mark wakes", awake_o, 1);

      highs(2);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200_000 * 5);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL R1 run timeout actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule